// File: doc/BRIEF.md
# Load/Store Access Unit

This block connects the integer pipeline of a 32-bit or 64-bit core to a byte-addressed data memory port. The pipeline presents one load or store at a time as an instruction word together with the base register value and, for stores, the source data register value. The unit adds the sign-extended 12-bit offset to the base to form the effective address. It checks the encoding and the alignment for the access width, and only a legal, acceptable access becomes a single-cycle memory request.

The request carries the address, a size code, a write flag, byte-lane enables and lane-aligned write data. The unit then waits for the memory response while holding `busy` high, so that only one access is ever in flight. A load response is shifted down from its byte lane and sign- or zero-extended before it is handed to the register file. A memory error response becomes an access-fault exception carrying the access address.

Misaligned and illegal accesses never reach memory: the unit raises an exception one cycle after accepting them. A platform input, `misalignOk`, turns the alignment check off altogether.

Top module: `mem_access_unit`

## Requirements
- R1: The effective address is `baseVal` plus the sign-extended 12-bit offset. For a load the offset is `instrWord[31:20]`. For a store it is `{instrWord[31:25], instrWord[11:7]}`. It appears on `memAddr` during the request cycle, which is the cycle after acceptance.
- R2: `instrWord[13:12]` gives the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. It is driven on `memSize`. `memWrite` is 1 for a store (opcode `instrWord[6:0]` = 7'b0100011) and 0 for a load (opcode 7'b0000011).
- R3: An access of N bytes is misaligned when the effective address modulo N is not zero, so a byte access is never misaligned. With `misalignOk` low, no request with a misaligned address is ever issued.
- R4: A misaligned load raises `excValid` with cause 4, and a misaligned store raises it with cause 6. The pulse appears in the cycle after acceptance, `excAddr` holds the effective address, no request is issued, nothing is written back and `busy` stays low.
- R5: While `misalignOk` is high, the alignment check never faults and a misaligned access is issued to memory like any other.
- R6: The unit raises cause 2 with no request for any of these: an opcode that is neither load nor store, an 8-byte access when XLEN is 32, a store with `instrWord[14]` set, or a zero-extending load (`instrWord[14]` = 1) whose width is not smaller than XLEN. Illegal encoding takes priority over misalignment.
- R7: `memBe` enables the lanes from `addr mod (XLEN/8)` up to that offset plus the size minus one. Lanes beyond the bus width are dropped.
- R8: On a store, enabled lane offset+k carries byte k of `storeVal`, for k counted from 0.
- R9: Load data is taken from `memRdata` starting at lane `addr mod (XLEN/8)`. Lanes past the bus top read as zero. The result is zero-extended when `instrWord[14]` is 1 and sign-extended when it is 0.
- R10: An error response (`memRspErr`) raises cause 5 for a load or cause 7 for a store, with `excAddr` equal to the request address, and suppresses the write-back.
- R11: `memReqValid` is a one-cycle pulse. `busy` is high from the request cycle until the edge at which the response is taken. A `reqValid` seen while `busy` is high is ignored.
- R12: A successful load gives a one-cycle `wbValid` pulse in the cycle after the response, with `wbRd` = `instrWord[11:7]`. A successful store completes with no `wbValid` and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access offered by the pipeline (taken when not busy) |
| instrWord | input | 32 | Load or store instruction word |
| baseVal | input | XLEN | Base register value |
| storeVal | input | XLEN | Store data register value |
| misalignOk | input | 1 | Platform switch that disables the alignment check |
| busy | output | 1 | Access in flight; the pipeline must hold |
| memReqValid | output | 1 | Memory request strobe |
| memAddr | output | XLEN | Request byte address |
| memSize | output | 2 | Log2 of access bytes |
| memWrite | output | 1 | Request is a store |
| memWdata | output | XLEN | Lane-aligned store data |
| memBe | output | XLEN/8 | Byte-lane enables |
| memRspValid | input | 1 | Memory response strobe |
| memRspErr | input | 1 | Response carries an access error |
| memRdata | input | XLEN | Response data, lane-aligned |
| wbValid | output | 1 | Load result valid |
| wbRd | output | 5 | Destination register index |
| wbData | output | XLEN | Extended load result |
| excValid | output | 1 | Exception pulse |
| excCause | output | 4 | Exception cause code |
| excAddr | output | XLEN | Faulting address |

## Verification
The bench aims at the alignment edges: byte accesses on odd addresses, half, word and double accesses one lane off, and the same accesses with `misalignOk` set. A design with a wrong alignment mask would either fault on a legal address or send a bad one to memory. It also covers negative offsets, which catch missing sign extension of the split store immediate. It covers the illegal zero-extending and double-width encodings, where a loose decoder would issue a request it should refuse. Finally it checks sign-extended loads whose top data bit is set, error responses for both directions, and a second request offered while busy, which a unit without a proper hold would accept and corrupt.

// File: rtl/mau_pkg.sv
package mau_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } mauState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // accept a legal access into the request registers
    logic earlyFault;  // accept an access that faults before memory
    logic finish;      // memory response taken
  } mauStrobe_t;

  localparam logic [3:0] CAUSE_ILLEGAL     = 4'd2;
  localparam logic [3:0] CAUSE_LD_MISALIGN = 4'd4;
  localparam logic [3:0] CAUSE_LD_FAULT    = 4'd5;
  localparam logic [3:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [3:0] CAUSE_ST_FAULT    = 4'd7;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       opFault,
  input  logic       memRspValid,
  output mauStrobe_t strobe,
  output logic       busy,
  output logic       memReqValid
);
  mauState_t state, stateNext;

  always_comb begin
    strobe.capture    = (state == ST_IDLE) && reqValid && !opFault;
    strobe.earlyFault = (state == ST_IDLE) && reqValid && opFault;
    strobe.finish     = (state == ST_WAIT) && memRspValid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.capture) stateNext = ST_REQ;
      ST_REQ:  stateNext = ST_WAIT;
      ST_WAIT: if (strobe.finish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_REQ);
endmodule

// File: rtl/mau_datapath.sv
module mau_datapath
  import mau_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [31:0]           instrWord,
  input  logic [XLEN-1:0]       baseVal,
  input  logic [XLEN-1:0]       storeVal,
  input  logic                  misalignOk,
  input  mauStrobe_t            strobe,
  input  logic                  memRspErr,
  input  logic [XLEN-1:0]       memRdata,
  output logic                  opFault,
  output logic [XLEN-1:0]       memAddr,
  output logic [1:0]            memSize,
  output logic                  memWrite,
  output logic [XLEN-1:0]       memWdata,
  output logic [XLEN/8-1:0]     memBe,
  output logic                  wbValid,
  output logic [4:0]            wbRd,
  output logic [XLEN-1:0]       wbData,
  output logic                  excValid,
  output logic [3:0]            excCause,
  output logic [XLEN-1:0]       excAddr
);
  localparam int BYTES     = XLEN / 8;
  localparam int OFFW      = $clog2(BYTES);
  localparam int LOG_BYTES = OFFW;

  // ---- decode and address ----
  logic        isLoad, isStore, zextSel, illegalOp, misaligned;
  logic [1:0]  sizeCode;
  logic [11:0] offImm;
  logic [3:0]  spanMask;
  logic [XLEN-1:0] effAddr;
  logic [OFFW-1:0] laneOff;
  logic [3:0]  earlyCause;

  always_comb begin
    isLoad   = (instrWord[6:0] == OPC_LOAD);
    isStore  = (instrWord[6:0] == OPC_STORE);
    sizeCode = instrWord[13:12];
    zextSel  = instrWord[14];
    offImm   = isStore ? {instrWord[31:25], instrWord[11:7]} : instrWord[31:20];
    effAddr  = baseVal + {{(XLEN-12){offImm[11]}}, offImm};
    laneOff  = effAddr[OFFW-1:0];
    spanMask = (4'd1 << sizeCode) - 4'd1;
    illegalOp = (!isLoad && !isStore)
             || (int'(sizeCode) > LOG_BYTES)
             || (zextSel && (isStore || int'(sizeCode) >= LOG_BYTES));
    misaligned = !misalignOk && ((effAddr[2:0] & spanMask[2:0]) != 3'd0);
    opFault    = illegalOp || misaligned;
    earlyCause = illegalOp ? CAUSE_ILLEGAL
               : (isStore ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN);
  end

  // ---- lane enables and rotated store data ----
  logic [BYTES-1:0] beNext;
  logic [XLEN-1:0]  wdataNext;
  always_comb begin
    int spanBytes;
    int relIdx;
    spanBytes = int'(32'd1 << sizeCode);
    beNext    = '0;
    wdataNext = '0;
    for (int i = 0; i < BYTES; i++) begin
      relIdx = (i - int'(laneOff)) & (spanBytes - 1) & (BYTES - 1);
      beNext[i] = (i >= int'(laneOff)) && (i < int'(laneOff) + spanBytes);
      wdataNext[i*8 +: 8] = storeVal[relIdx*8 +: 8];
    end
  end

  // ---- request registers ----
  logic       zextQ;
  logic [4:0] rdQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memSize  <= '0;
      memWrite <= 1'b0;
      memWdata <= '0;
      memBe    <= '0;
      zextQ    <= 1'b0;
      rdQ      <= '0;
    end else if (strobe.capture) begin
      memAddr  <= effAddr;
      memSize  <= sizeCode;
      memWrite <= isStore;
      memWdata <= wdataNext;
      memBe    <= beNext;
      zextQ    <= zextSel;
      rdQ      <= instrWord[11:7];
    end
  end

  // ---- load alignment and extension ----
  logic [XLEN-1:0] shiftedData, loadExt;
  always_comb begin
    int topBit;
    logic fillBit;
    shiftedData = memRdata >> {memAddr[OFFW-1:0], 3'b000};
    topBit = (8 << memSize) - 1;
    if (topBit > XLEN - 1) topBit = XLEN - 1;
    fillBit = !zextQ && shiftedData[topBit];
    for (int b = 0; b < XLEN; b++) begin
      loadExt[b] = (b <= topBit) ? shiftedData[b] : fillBit;
    end
  end

  // ---- result registers ----
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid  <= 1'b0;
      wbRd     <= '0;
      wbData   <= '0;
      excValid <= 1'b0;
      excCause <= '0;
      excAddr  <= '0;
    end else begin
      wbValid  <= strobe.finish && !memRspErr && !memWrite;
      excValid <= strobe.earlyFault || (strobe.finish && memRspErr);
      if (strobe.finish) begin
        wbRd   <= rdQ;
        wbData <= loadExt;
      end
      if (strobe.earlyFault) begin
        excCause <= earlyCause;
        excAddr  <= effAddr;
      end else if (strobe.finish && memRspErr) begin
        excCause <= memWrite ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
        excAddr  <= memAddr;
      end
    end
  end
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [31:0]           instrWord,
  input  logic [XLEN-1:0]       baseVal,
  input  logic [XLEN-1:0]       storeVal,
  input  logic                  misalignOk,
  output logic                  busy,
  output logic                  memReqValid,
  output logic [XLEN-1:0]       memAddr,
  output logic [1:0]            memSize,
  output logic                  memWrite,
  output logic [XLEN-1:0]       memWdata,
  output logic [XLEN/8-1:0]     memBe,
  input  logic                  memRspValid,
  input  logic                  memRspErr,
  input  logic [XLEN-1:0]       memRdata,
  output logic                  wbValid,
  output logic [4:0]            wbRd,
  output logic [XLEN-1:0]       wbData,
  output logic                  excValid,
  output logic [3:0]            excCause,
  output logic [XLEN-1:0]       excAddr
);
  mauStrobe_t strobe;
  logic       opFault;

  mau_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .opFault     (opFault),
    .memRspValid (memRspValid),
    .strobe      (strobe),
    .busy        (busy),
    .memReqValid (memReqValid)
  );

  mau_datapath #(.XLEN(XLEN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instrWord  (instrWord),
    .baseVal    (baseVal),
    .storeVal   (storeVal),
    .misalignOk (misalignOk),
    .strobe     (strobe),
    .memRspErr  (memRspErr),
    .memRdata   (memRdata),
    .opFault    (opFault),
    .memAddr    (memAddr),
    .memSize    (memSize),
    .memWrite   (memWrite),
    .memWdata   (memWdata),
    .memBe      (memBe),
    .wbValid    (wbValid),
    .wbRd       (wbRd),
    .wbData     (wbData),
    .excValid   (excValid),
    .excCause   (excCause),
    .excAddr    (excAddr)
  );
endmodule

// File: rtl/mau_checker.sv
module mau_checker #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              misalignOk,
  input logic              busy,
  input logic              memReqValid,
  input logic [XLEN-1:0]   memAddr,
  input logic [1:0]        memSize,
  input logic [XLEN/8-1:0] memBe,
  input logic              wbValid,
  input logic              excValid,
  input logic [3:0]        excCause
);
  logic [3:0] sizeMask;
  assign sizeMask = (4'd1 << memSize) - 4'd1;

  // R3
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !$past(misalignOk) |-> ((memAddr[2:0] & sizeMask[2:0]) == 3'd0));

  // R4
  early_fault_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid && (excCause == 4'd4 || excCause == 4'd6) |-> !$past(busy));

  // R7
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memBe != '0));

  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R12
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);

  // R10
  wb_exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wbValid && excValid));
endmodule

bind mem_access_unit mau_checker #(.XLEN(XLEN)) u_mau_checker (
  .clk         (clk),
  .rstN        (rstN),
  .misalignOk  (misalignOk),
  .busy        (busy),
  .memReqValid (memReqValid),
  .memAddr     (memAddr),
  .memSize     (memSize),
  .memBe       (memBe),
  .wbValid     (wbValid),
  .excValid    (excValid),
  .excCause    (excCause)
);

// File: tb/mem_access_unit_bench.sv
module mem_access_unit_bench;
  localparam int XLEN     = 64;
  localparam int BYTES    = XLEN / 8;
  localparam int CLK_HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [XLEN-1:0] baseVal = '0, storeVal = '0;
  logic misalignOk = 1'b0;
  logic busy, memReqValid, memWrite;
  logic [XLEN-1:0] memAddr, memWdata;
  logic [1:0] memSize;
  logic [BYTES-1:0] memBe;
  logic memRspValid = 1'b0, memRspErr = 1'b0;
  logic [XLEN-1:0] memRdata = '0;
  logic wbValid, excValid;
  logic [4:0] wbRd;
  logic [XLEN-1:0] wbData, excAddr;
  logic [3:0] excCause;

  int checks = 0;
  int fails = 0;

  always #(CLK_HALF) clk = ~clk;

  mem_access_unit #(.XLEN(XLEN)) u_mem_access_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .instrWord(instrWord),
    .baseVal(baseVal), .storeVal(storeVal), .misalignOk(misalignOk),
    .busy(busy), .memReqValid(memReqValid), .memAddr(memAddr),
    .memSize(memSize), .memWrite(memWrite), .memWdata(memWdata),
    .memBe(memBe), .memRspValid(memRspValid), .memRspErr(memRspErr),
    .memRdata(memRdata), .wbValid(wbValid), .wbRd(wbRd), .wbData(wbData),
    .excValid(excValid), .excCause(excCause), .excAddr(excAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkLoad(input logic [11:0] imm, input logic [2:0] f3,
                                         input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] mkStore(input logic [11:0] imm, input logic [2:0] f3);
    return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
  endfunction

  function automatic logic [XLEN-1:0] fAddr(input logic [31:0] ins, input logic [XLEN-1:0] b);
    logic [11:0] imm;
    logic signed [XLEN-1:0] sx;
    imm = (ins[6:0] == 7'b0100011) ? {ins[31:25], ins[11:7]} : ins[31:20];
    sx = XLEN'(signed'(imm));
    return b + sx;
  endfunction

  function automatic int fCause(input logic [31:0] ins, input logic [XLEN-1:0] a,
                                input logic mok);
    bit ld, st;
    int nb;
    ld = (ins[6:0] == 7'b0000011);
    st = (ins[6:0] == 7'b0100011);
    nb = 1 << ins[13:12];
    if (!ld && !st) return 2;
    if (nb > BYTES) return 2;
    if (ins[14] && (st || nb >= BYTES)) return 2;
    if (!mok && (a % nb) != 0) return st ? 6 : 4;
    return 0;
  endfunction

  function automatic logic [BYTES-1:0] fBe(input int off, input int nb);
    logic [BYTES-1:0] be = '0;
    for (int k = 0; k < nb; k++) if (off + k < BYTES) be[off + k] = 1'b1;
    return be;
  endfunction

  function automatic logic [XLEN-1:0] fLoad(input logic [XLEN-1:0] rd, input int off,
                                            input int nb, input bit zx);
    logic [XLEN-1:0] v = '0;
    for (int k = 0; k < nb; k++)
      if (off + k < BYTES) v[k*8 +: 8] = rd[(off + k)*8 +: 8];
    if (!zx && nb < BYTES && v[nb*8-1])
      for (int b = nb*8; b < XLEN; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic runOp(input logic [31:0] ins, input logic [XLEN-1:0] b,
                       input logic [XLEN-1:0] sv, input logic mok, input int lat,
                       input bit err, input logic [XLEN-1:0] rdat, input bit intrude);
    logic [XLEN-1:0] a;
    int cause, off, nb;
    bit st;
    @(negedge clk);
    instrWord = ins; baseVal = b; storeVal = sv; misalignOk = mok; reqValid = 1'b1;
    a = fAddr(ins, b);
    cause = fCause(ins, a, mok);
    off = int'(a % BYTES);
    nb = 1 << ins[13:12];
    st = (ins[6:0] == 7'b0100011);
    @(negedge clk);
    reqValid = 1'b0;
    if (cause != 0) begin
      chk(excValid === 1'b1, (cause == 2) ? "R6 excValid" : "R4 excValid", XLEN'(excValid), 1);
      chk(excCause === 4'(cause), (cause == 2) ? "R6 cause" : "R4 cause", XLEN'(excCause), XLEN'(cause));
      chk(excAddr === a, "R4 excAddr", excAddr, a);
      chk(memReqValid === 1'b0 && busy === 1'b0, "R4 no request", XLEN'(memReqValid), 0);
      @(negedge clk);
      chk(wbValid === 1'b0 && memReqValid === 1'b0, "R4 no writeback", XLEN'(wbValid), 0);
      return;
    end
    chk(excValid === 1'b0, "R5 no fault", XLEN'(excValid), 0);
    chk(memReqValid === 1'b1 && busy === 1'b1, "R11 request", XLEN'(memReqValid), 1);
    chk(memAddr === a, "R1 address", memAddr, a);
    chk(memSize === ins[13:12] && memWrite === st, "R2 size/write",
        XLEN'({memWrite, memSize}), XLEN'({st, ins[13:12]}));
    chk(memBe === fBe(off, nb), "R7 byte enables", XLEN'(memBe), XLEN'(fBe(off, nb)));
    if (st) begin
      for (int k = 0; k < nb; k++)
        if (off + k < BYTES)
          chk(memWdata[(off+k)*8 +: 8] === sv[k*8 +: 8], "R8 lane data",
              XLEN'(memWdata[(off+k)*8 +: 8]), XLEN'(sv[k*8 +: 8]));
    end
    for (int i = 0; i < lat; i++) begin
      if (intrude && i == 0) begin
        instrWord = mkLoad(12'h001, 3'b010, 5'd9); baseVal = '0; misalignOk = 1'b0;
        reqValid = 1'b1;
      end
      @(negedge clk);
      reqValid = 1'b0;
      chk(memReqValid === 1'b0 && excValid === 1'b0 && busy === 1'b1, "R11 hold",
          XLEN'({busy, excValid, memReqValid}), XLEN'(3'b100));
    end
    memRspValid = 1'b1; memRspErr = err; memRdata = rdat;
    @(negedge clk);
    memRspValid = 1'b0; memRspErr = 1'b0;
    chk(busy === 1'b0, "R11 busy release", XLEN'(busy), 0);
    if (err) begin
      chk(excValid === 1'b1 && excCause === (st ? 4'd7 : 4'd5), "R10 fault cause",
          XLEN'(excCause), st ? 7 : 5);
      chk(excAddr === a && wbValid === 1'b0, "R10 fault addr", excAddr, a);
    end else if (!st) begin
      chk(wbValid === 1'b1 && wbRd === ins[11:7], "R12 writeback", XLEN'(wbRd), XLEN'(ins[11:7]));
      chk(wbData === fLoad(rdat, off, nb, ins[14]), "R9 load data", wbData,
          fLoad(rdat, off, nb, ins[14]));
    end else begin
      chk(wbValid === 1'b0 && excValid === 1'b0, "R12 store done", XLEN'(wbValid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && memReqValid === 1'b0 && wbValid === 1'b0 && excValid === 1'b0,
        "R11 reset state", XLEN'({busy, memReqValid, wbValid, excValid}), 0);

    // directed corners
    runOp(mkLoad(12'h003, 3'b000, 5'd5), 64'h1000, '0, 0, 1, 0, 64'h0000_00F0_0000_0000, 0); // R3 byte odd
    runOp(mkLoad(12'h004, 3'b000, 5'd6), 64'h1000, '0, 0, 2, 0, 64'h0000_0080_0000_0000, 0); // R9 LB negative
    runOp(mkLoad(12'h004, 3'b100, 5'd6), 64'h1000, '0, 0, 1, 0, 64'h0000_0080_0000_0000, 0); // R9 LBU
    runOp(mkLoad(12'h001, 3'b001, 5'd7), 64'h1000, '0, 0, 1, 0, '0, 0);  // R4 half odd
    runOp(mkLoad(12'h002, 3'b010, 5'd7), 64'h1000, '0, 0, 1, 0, '0, 0);  // R4 word at 2
    runOp(mkStore(12'h004, 3'b011), 64'h1000, '1, 0, 1, 0, '0, 0);       // R4 store double at 4
    runOp(mkLoad(12'h004, 3'b110, 5'd8), 64'h1000, '0, 0, 1, 0, 64'h8765_4321_0000_0000, 0); // R9 LWU
    runOp(mkLoad(12'h004, 3'b010, 5'd8), 64'h1000, '0, 0, 1, 0, 64'h8765_4321_0000_0000, 0); // R9 LW sign
    runOp(mkLoad(12'h000, 3'b011, 5'd9), 64'h2000, '0, 0, 3, 0, 64'hFEDC_BA98_7654_3210, 0); // R9 LD
    runOp(mkLoad(12'h000, 3'b111, 5'd9), 64'h2000, '0, 0, 1, 0, '0, 0);  // R6 zext double
    runOp(mkStore(12'h000, 3'b100), 64'h2000, '0, 0, 1, 0, '0, 0);       // R6 store zext bit
    runOp({25'h0, 7'b0010011}, 64'h2000, '0, 0, 1, 0, '0, 0);            // R6 bad opcode
    runOp(mkStore(12'h802, 3'b001), 64'h3000, 64'hA1B2_C3D4_E5F6_0718, 0, 1, 0, '0, 0); // R1 neg offset
    runOp(mkStore(12'h006, 3'b010), 64'h3000, 64'h1122_3344_5566_7788, 1, 2, 0, '0, 0); // R5 spill
    runOp(mkLoad(12'h003, 3'b001, 5'd3), 64'h3000, '0, 1, 1, 0, 64'hFFEE_DDCC_BBAA_9988, 0); // R5 load
    runOp(mkLoad(12'h008, 3'b011, 5'd4), 64'h3000, '0, 0, 2, 1, '0, 0);  // R10 load error
    runOp(mkStore(12'h010, 3'b000), 64'h3000, 64'h55, 0, 1, 1, '0, 0);   // R10 store error
    runOp(mkLoad(12'h010, 3'b010, 5'd11), 64'h3000, '0, 0, 3, 0, 64'h0000_0000_7FFF_FFFF, 1); // R11 intrude

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [11:0] imm;
      logic [2:0] f3;
      logic [XLEN-1:0] b, sv, rd;
      logic [31:0] ins;
      imm = 12'($urandom);
      f3  = 3'($urandom);
      b   = {$urandom, $urandom};
      sv  = {$urandom, $urandom};
      rd  = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) b[2:0] = 3'b000;
      if ($urandom_range(0, 1) != 0) imm[2:0] = 3'($urandom_range(0, 1) * 4);
      ins = ($urandom_range(0, 1) != 0) ? mkStore(imm, f3) : mkLoad(imm, f3, 5'($urandom));
      runOp(ins, b, sv, 1'($urandom_range(0, 3) == 0), int'($urandom_range(1, 4)),
            $urandom_range(0, 7) == 0, rd, $urandom_range(0, 5) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule